// File: doc/BRIEF.md
# Dual-Polynomial Side-Stream Scrambler Register

This block produces the side-stream scrambling sequence for a transmitter that sends PAM-5 symbols on four wire pairs at once. A 33-bit linear feedback shift register moves one step for every symbol period, which is 8 ns at a 125 MHz symbol clock. The whole register is presented to a downstream word generator on every cycle. The word generator uses that state to build the data and sign scramble words.

One register serves both ends of a link. A role input selects the feedback polynomial. The master end uses 1 + x^13 + x^33 and the slave end uses 1 + x^20 + x^33, so the two ends send sequences that are not correlated. The role is captured only at a reset or a seed load, so the polynomial never changes partway through a sequence. A seed port sets the starting state. A zero seed would lock the register at zero, so it is replaced by a fixed nonzero default.

The state output is a plain per-cycle value with no handshake. The enable input is the only pacing control: the downstream logic pulses it once per symbol, and while it is low the state holds.

Top module: `ssr_dual_lfsr`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the state becomes the default seed 33'h1_2345_6789. The role input is captured at the same edge.
- R2: When the captured role is master (`role_sel` = 0) and the register steps, it shifts up by one. Bit 0 takes the XOR of old bits 32 and 12, which is the polynomial 1 + x^13 + x^33.
- R3: When the captured role is slave (`role_sel` = 1) and the register steps, it shifts up by one. Bit 0 takes the XOR of old bits 32 and 19, which is the polynomial 1 + x^20 + x^33.
- R4: A high `load` with `rst` low writes a nonzero `seed` into the state at the next edge. `load` takes priority over `en`.
- R5: A load with an all-zero `seed` writes the default seed 33'h1_2345_6789 in its place.
- R6: With `rst`, `load` and `en` all low, the state holds its value.
- R7: A change of `role_sel` has no effect on the feedback until the next reset or load. Only that next reset or load captures the new role.
- R8: After reset, the state is never all zeros.
- R9: Started from the same seed, the master and slave sequences differ within the first 40 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load the seed and capture the role |
| role_sel | input | 1 | 0 = master polynomial, 1 = slave polynomial |
| seed | input | 33 | Starting state applied on a load |
| state | output | 33 | Current register state |

## Verification
The in-module assertions check several rules on every cycle: the one-position shift, the feedback bit for the captured role, holding while idle, load priority, zero-seed substitution, the role staying latched between loads, and the state never being zero. Only the bench scenarios can show the long-run properties. These are that a whole sequence matches an independent model from every one-hot seed in both roles, and that the two polynomials give different streams from the same seed. A role change partway through a sequence is also checked by the bench, which compares the stream against the model for the old role.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/ssr_tap_sel.sv
module ssr_tap_sel #(
  parameter int WIDTH  = 33,
  parameter int TAP_M  = 13,
  parameter int TAP_S  = 20
) (
  input  logic [WIDTH-1:0] cur,
  input  ssr_pkg::role_e   role,
  output logic             fb
);
  localparam int NROLES = 2;

  function automatic logic [WIDTH-1:0] tap_mask(input int t);
    logic [WIDTH-1:0] m;
    m = '0;
    m[t-1] = 1'b1;
    m[WIDTH-1] = 1'b1;
    return m;
  endfunction

  logic [NROLES-1:0] fb_role;

  for (genvar g = 0; g < NROLES; g++) begin : g_role
    localparam int TAP = (g == 0) ? TAP_M : TAP_S;
    localparam logic [WIDTH-1:0] MASK = tap_mask(TAP);
    assign fb_role[g] = ^(cur & MASK);
  end

  assign fb = (role == ssr_pkg::ROLE_SLAVE) ? fb_role[1] : fb_role[0];
endmodule

// File: rtl/ssr_seed_guard.sv
module ssr_seed_guard #(
  parameter int               WIDTH = 33,
  parameter logic [WIDTH-1:0] DEF   = 33'h1_2345_6789
) (
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] seed_ok
);
  logic is_zero;
  assign is_zero = (seed_in == '0);
  assign seed_ok = is_zero ? DEF : seed_in;
endmodule

// File: rtl/ssr_state_reg.sv
module ssr_state_reg #(
  parameter int               WIDTH = 33,
  parameter int               TAP_M = 13,
  parameter int               TAP_S = 20,
  parameter logic [WIDTH-1:0] DEF   = 33'h1_2345_6789
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  ssr_pkg::role_e   role_in,
  input  logic [WIDTH-1:0] seed_raw,
  input  logic [WIDTH-1:0] seed_ok,
  input  logic             fb,
  output logic [WIDTH-1:0] st,
  output ssr_pkg::role_e   role_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= DEF;
      role_q <= role_in;
    end else if (load) begin
      st     <= seed_ok;
      role_q <= role_in;
    end else if (en) begin
      st     <= {st[WIDTH-2:0], fb};
    end
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> st[WIDTH-1:1] == $past(st[WIDTH-2:0]));

  assert_fb_master_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && role_q == ssr_pkg::ROLE_MASTER)
      |=> st[0] == ($past(st[WIDTH-1]) ^ $past(st[TAP_M-1])));

  assert_fb_slave_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !load && role_q == ssr_pkg::ROLE_SLAVE)
      |=> st[0] == ($past(st[WIDTH-1]) ^ $past(st[TAP_S-1])));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    (load && seed_raw != '0) |=> st == $past(seed_raw));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (rst)
    (load && seed_raw == '0) |=> st == DEF);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(st));

  assert_role_lock_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(role_q));

  assert_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    st != '0);
endmodule

// File: rtl/ssr_dual_lfsr.sv
module ssr_dual_lfsr #(
  parameter int               WIDTH = 33,
  parameter int               TAP_M = 13,
  parameter int               TAP_S = 20,
  parameter logic [WIDTH-1:0] DEF   = 33'h1_2345_6789
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic             role_sel,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);
  ssr_pkg::role_e   role_in;
  ssr_pkg::role_e   role_q;
  logic [WIDTH-1:0] seed_ok;
  logic [WIDTH-1:0] st;
  logic             fb;

  assign role_in = ssr_pkg::role_e'(role_sel);

  ssr_seed_guard #(.WIDTH(WIDTH), .DEF(DEF)) u_guard (
    .seed_in (seed),
    .seed_ok (seed_ok)
  );

  ssr_tap_sel #(.WIDTH(WIDTH), .TAP_M(TAP_M), .TAP_S(TAP_S)) u_taps (
    .cur  (st),
    .role (role_q),
    .fb   (fb)
  );

  ssr_state_reg #(.WIDTH(WIDTH), .TAP_M(TAP_M), .TAP_S(TAP_S), .DEF(DEF)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .role_in  (role_in),
    .seed_raw (seed),
    .seed_ok  (seed_ok),
    .fb       (fb),
    .st       (st),
    .role_q   (role_q)
  );

  assign state = st;
endmodule

// File: tb/test_ssr_dual_lfsr.sv
module test_ssr_dual_lfsr;
  localparam logic [32:0] DEF = 33'h1_2345_6789;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic        role_sel = 1'b0;
  logic [32:0] seed = '0;
  logic [32:0] state;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ssr_dual_lfsr i_ssr_dual_lfsr (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .role_sel(role_sel), .seed(seed), .state(state)
  );

  function automatic logic [32:0] nxt(input logic [32:0] s, input logic r);
    return {s[31:0], s[32] ^ (r ? s[19] : s[12])};
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r_, input logic l_, input logic e_, input logic ro, input logic [32:0] sd);
    @(negedge clk);
    rst = r_; load = l_; en = e_; role_sel = ro; seed = sd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [32:0] m;
    logic [32:0] ma;
    logic        differ;
    cyc(1, 0, 0, 0, '0);
    cyc(0, 0, 0, 0, '0);
    chk("R1", state, DEF);

    // R2 / R3 / R8: one-hot seed sweep in both roles
    for (int ro = 0; ro < 2; ro++) begin
      for (int b = 0; b < 33; b++) begin
        cyc(0, 1, 1, ro[0], 33'd1 << b);
        m = 33'd1 << b;
        chk("R4", state, m);
        for (int k = 0; k < 40; k++) begin
          cyc(0, 0, 1, ro[0], '0);
          m = nxt(m, ro[0]);
          chk(ro == 0 ? "R2" : "R3", state, m);
          n_chk++;
          if (state == '0) begin
            n_fail++;
            $display("FAIL R8 actual=%h expected=nonzero", state);
          end
        end
      end
    end

    // R5 zero seed
    cyc(0, 1, 0, 0, '0);
    chk("R5", state, DEF);

    // R6 hold
    m = state;
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, k[0], 33'h0_FFFF_0000);
      chk("R6", state, m);
    end

    // R7 role change mid-sequence is ignored
    cyc(0, 1, 0, 0, 33'h0_0F0F_1234);
    m = 33'h0_0F0F_1234;
    for (int k = 0; k < 60; k++) begin
      cyc(0, 0, 1, 1, '0);
      m = nxt(m, 1'b0);
      chk("R7", state, m);
    end
    // new role captured at load
    cyc(0, 1, 0, 1, 33'h0_0F0F_1234);
    m = 33'h0_0F0F_1234;
    for (int k = 0; k < 60; k++) begin
      cyc(0, 0, 1, 0, '0);
      m = nxt(m, 1'b1);
      chk("R7", state, m);
    end
    // role captured at reset
    cyc(1, 0, 0, 1, '0);
    cyc(0, 0, 1, 0, '0);
    chk("R1", state, nxt(DEF, 1'b1));

    // R9 master and slave differ from a common seed
    ma = 33'h1_0000_0001;
    m = ma;
    differ = 1'b0;
    for (int k = 0; k < 40; k++) begin
      ma = nxt(ma, 1'b0);
      m = nxt(m, 1'b1);
      if (ma != m) differ = 1'b1;
    end
    cyc(0, 1, 0, 0, 33'h1_0000_0001);
    for (int k = 0; k < 40; k++) cyc(0, 0, 1, 0, '0);
    chk("R9", state, ma);
    cyc(0, 1, 0, 1, 33'h1_0000_0001);
    for (int k = 0; k < 40; k++) cyc(0, 0, 1, 1, '0);
    chk("R9", state, m);
    chk("R9", {32'd0, differ}, 33'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule